// File: doc/BRIEF.md
# Hart Debug Control and Status Registers

This block gives an external debugger register-level control over a small group of processor harts. The debugger uses a plain access port (address, write data, write enable, read enable, registered read data) to reach two registers. The control register chooses a set of harts and, in the same write, asks that set to halt, resume, enter or leave reset, or acknowledge a reset it has seen. The status register reports whether any or all of the currently chosen harts are halted, running, have acknowledged their last resume, or have an unacknowledged reset. It also carries a sticky error code for bad accesses.

Each hart gets a level halt request, a resume request held until the hart reports it is running, and an optional reset level. The harts report their halted and running state, and give a one-cycle pulse when they come out of a reset. Hart reset drive can be left out at build time. In that case the reset bit always reads as zero, so software can detect that the feature is missing.

Top module: `hart_dbg_ctrl`

## Requirements
- R1: The control register is at address 0x10 and the status register at 0x11. The data for a read appears on `acc_rdata` in the cycle after the read enable is seen, and is 0 when no read was made. A read of any other address returns 0.
- R2: Hart selection is set by control fields. Bit 26 is the mode, bits 25:16 are the hart index and bits 15:0 are the mask, with mask bit i standing for hart i. In mode 0 only the indexed hart is selected, and an index at or beyond the hart count selects none. In mode 1 the indexed hart and every hart whose mask bit is 1 are selected.
- R3: A control write sets `hart_halt_req` of each selected hart to write bit 31, visible from the next cycle. Harts that are not selected keep their request.
- R4: A control write with bit 30 = 1 and bit 31 = 0 raises `hart_resume_req` for each selected hart that is halted. The request stays high until that hart reports running. Harts that are not halted get no request.
- R5: A resume bit written together with bit 31 = 1 has no effect.
- R6: Each hart's resume-acknowledge flag is cleared when a resume is issued to it and set when its pending resume completes. Status bit 17 reads 1 when every selected hart has the flag set, and bit 16 reads 1 when any does. Both flags are 0 after reset.
- R7: Control bit 29 is a reset level driven on `hart_reset` of each selected hart. When read back, bit 29 shows the reset level of the indexed hart. When reset support is not built in, the output and the readback stay 0.
- R8: A hart's reset-seen flag is set by a pulse on `hart_reset_event` and stays set. Status bit 19 is 1 when every selected hart has the flag set, and bit 18 is 1 when any does.
- R9: A control write with bit 28 = 1 clears the reset-seen flag of each selected hart. A reset pulse in that same cycle leaves the flag set.
- R10: The halt, resume, reset and acknowledge actions of a write use the selection carried in that same write.
- R11: Status bits 9 and 8 give the all and any halted summaries over the selected harts, and bits 11 and 10 give the same for running. With no hart selected, every "all" and "any" bit reads 0.
- R12: The error field is status bits 26:24. Code 1 records a read or write to an unimplemented address. Code 7 records write and read enabled in the same cycle, and that access has no other effect. The first code is kept until a status write with bits 26:24 = 111 clears it.
- R13: A control read returns mode, index and mask as written. Bits 31, 30 and 28 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_addr | input | ADDR_W | Register address |
| acc_wdata | input | 32 | Write data |
| acc_we | input | 1 | Write enable |
| acc_re | input | 1 | Read enable |
| hart_halted | input | N_HARTS | Hart is halted |
| hart_running | input | N_HARTS | Hart is running |
| hart_reset_event | input | N_HARTS | One-cycle pulse when a hart has been reset |
| acc_rdata | output | 32 | Registered read data |
| hart_halt_req | output | N_HARTS | Halt request level per hart |
| hart_resume_req | output | N_HARTS | Resume request per hart |
| hart_reset | output | N_HARTS | Reset level per hart |

## Verification
Two pairs of events can land on the same clock edge, and the bench forces both. In the first, a hart reports a reset while the debugger writes an acknowledge that selects that hart. The bench raises the reset pulse in the same cycle as the acknowledge write, then reads the status register: the any-reset bit must still be 1. A later acknowledge with no pulse must bring it back to 0. In the second, a write and a read are enabled together. The bench sends such an access carrying a halt request and then checks two things: that the halt outputs did not change, and which error code the status register holds. That code must be 7 when the field was clear, and the earlier code when it was not.

// File: rtl/hctl_pkg.sv
// Package: shared constants and types for the hart debug control block.
// Assumes a 32-bit register layout; field positions are fixed here.
package hctl_pkg;
    localparam int DATA_W = 32;
    localparam int SEL_W  = 10;
    localparam int MASK_W = 16;

    localparam logic [7:0] ADDR_CTRL = 8'h10;
    localparam logic [7:0] ADDR_STAT = 8'h11;

    // control register bit positions
    localparam int C_HALT   = 31;
    localparam int C_RESUME = 30;
    localparam int C_HRST   = 29;
    localparam int C_ACK    = 28;
    localparam int C_MODE   = 26;
    localparam int C_SEL_LO = 16;

    // status register bit positions
    localparam int S_ERR_LO   = 24;
    localparam int S_ALL_RST  = 19;
    localparam int S_ANY_RST  = 18;
    localparam int S_ALL_RACK = 17;
    localparam int S_ANY_RACK = 16;
    localparam int S_ALL_RUN  = 11;
    localparam int S_ANY_RUN  = 10;
    localparam int S_ALL_HLT  = 9;
    localparam int S_ANY_HLT  = 8;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_BADADDR = 3'd1,
        ERR_OTHER   = 3'd7
    } err_code_e;

    typedef struct packed {
        logic all_set;
        logic any_set;
    } summary_t;
endpackage

// File: rtl/hctl_sel_decode.sv
// Module: turns mode, hart index and mask into a one-bit-per-hart selection.
// Assumes N_HARTS <= MASK_W; an index beyond the hart count selects nothing.
module hctl_sel_decode
    import hctl_pkg::*;
#(
    parameter int N_HARTS = 4
) (
    input  logic                 mode,
    input  logic [SEL_W-1:0]     idx,
    input  logic [MASK_W-1:0]    mask,
    output logic [N_HARTS-1:0]   sel
);
    // one decode term per hart
    for (genvar i = 0; i < N_HARTS; i++) begin : g_sel
        assign sel[i] = (idx == SEL_W'(i)) | (mode & mask[i]);
    end
endmodule

// File: rtl/hctl_summary.sv
// Module: reduces a per-hart flag vector over a selection to any/all bits.
// Assumes an empty selection yields both bits 0.
module hctl_summary
    import hctl_pkg::*;
#(
    parameter int N_HARTS = 4
) (
    input  logic [N_HARTS-1:0] sel,
    input  logic [N_HARTS-1:0] flags,
    output summary_t           sum
);
    logic [N_HARTS-1:0] hit;

    // any/all over the selected harts
    always_comb begin
        hit         = sel & flags;
        sum.any_set = |hit;
        sum.all_set = (|sel) && (hit == sel);
    end
endmodule

// File: rtl/hctl_hart_slice.sv
// Module: per-hart request and flag state driven by control writes.
// Assumes wr_sel already reflects the selection carried in the current write,
// and that a hart cannot be halted and running at once.
module hctl_hart_slice #(
    parameter bit HAS_RESET = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ctrl,
    input  logic wr_sel,
    input  logic wr_halt,
    input  logic wr_resume,
    input  logic wr_hrst,
    input  logic wr_ack,
    input  logic halted,
    input  logic running,
    input  logic reset_event,
    output logic halt_req,
    output logic resume_req,
    output logic hrst,
    output logic seen,
    output logic rack
);
    logic halt_q, pend_q, seen_q, rack_q;
    logic hit, issue;

    assign hit   = wr_ctrl && wr_sel;
    assign issue = hit && wr_resume && !wr_halt && halted;

    // halt request level follows each write that selects this hart
    always_ff @(posedge clk) begin
        if (!rst_n)   halt_q <= 1'b0;
        else if (hit) halt_q <= wr_halt;
    end

    // resume request pending until running; ack flag tracks completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            rack_q <= 1'b0;
        end else if (issue) begin
            pend_q <= 1'b1;
            rack_q <= 1'b0;
        end else if (pend_q && running) begin
            pend_q <= 1'b0;
            rack_q <= 1'b1;
        end
    end

    // sticky reset-seen flag; a new reset beats an acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)                seen_q <= 1'b0;
        else if (reset_event)      seen_q <= 1'b1;
        else if (hit && wr_ack)    seen_q <= 1'b0;
    end

    if (HAS_RESET) begin : g_rst
        logic hrst_q;
        // reset level follows each write that selects this hart
        always_ff @(posedge clk) begin
            if (!rst_n)   hrst_q <= 1'b0;
            else if (hit) hrst_q <= wr_hrst;
        end
        assign hrst = hrst_q;
    end else begin : g_norst
        assign hrst = 1'b0;
    end

    assign halt_req   = halt_q;
    assign resume_req = pend_q;
    assign seen       = seen_q;
    assign rack       = rack_q;

    assert_halt_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (halt_q == $past(wr_halt)));
    assert_resume_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && wr_halt) |=> !$rose(pend_q));
    assert_seen_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !(hit && wr_ack)) |=> seen_q);
    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && wr_ack && !reset_event) |=> !seen_q);
endmodule

// File: rtl/hart_dbg_ctrl.sv
// Module: debugger-facing control/status registers for N_HARTS harts.
// Assumes a single access per cycle; write and read together is an error.
// Read data is registered and reflects state before the read edge.
module hart_dbg_ctrl
    import hctl_pkg::*;
#(
    parameter int N_HARTS   = 4,
    parameter int ADDR_W    = 7,
    parameter bit HAS_RESET = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic [31:0]         acc_wdata,
    input  logic                acc_we,
    input  logic                acc_re,
    input  logic [N_HARTS-1:0]  hart_halted,
    input  logic [N_HARTS-1:0]  hart_running,
    input  logic [N_HARTS-1:0]  hart_reset_event,
    output logic [31:0]         acc_rdata,
    output logic [N_HARTS-1:0]  hart_halt_req,
    output logic [N_HARTS-1:0]  hart_resume_req,
    output logic [N_HARTS-1:0]  hart_reset
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);

    logic                mode_q;
    logic [SEL_W-1:0]    idx_q;
    logic [N_HARTS-1:0]  mask_q;
    err_code_e           err_q;
    logic [31:0]         rdata_q;

    logic both, wr_ok, rd_ok, is_ctrl, is_stat, bad_addr, wr_ctrl, err_clr;
    logic [N_HARTS-1:0]  sel_new, sel_cur;
    logic [N_HARTS-1:0]  seen_v, rack_v;
    logic [MASK_W-1:0]   mask_ext;
    summary_t            s_hlt, s_run, s_rst, s_rack;
    logic [31:0]         ctrl_rd, stat_rd;
    logic                idx_rst;

    // access decode
    always_comb begin
        both     = acc_we && acc_re;
        wr_ok    = acc_we && !acc_re;
        rd_ok    = acc_re && !acc_we;
        is_ctrl  = (acc_addr == A_CTRL);
        is_stat  = (acc_addr == A_STAT);
        bad_addr = !is_ctrl && !is_stat;
        wr_ctrl  = wr_ok && is_ctrl;
        err_clr  = wr_ok && is_stat && (acc_wdata[S_ERR_LO+:3] == 3'b111);
        mask_ext = MASK_W'(mask_q);
    end

    hctl_sel_decode #(.N_HARTS(N_HARTS)) u_sel_new (
        .mode (acc_wdata[C_MODE]),
        .idx  (acc_wdata[C_SEL_LO+:SEL_W]),
        .mask (acc_wdata[MASK_W-1:0]),
        .sel  (sel_new)
    );

    hctl_sel_decode #(.N_HARTS(N_HARTS)) u_sel_cur (
        .mode (mode_q),
        .idx  (idx_q),
        .mask (mask_ext),
        .sel  (sel_cur)
    );

    for (genvar i = 0; i < N_HARTS; i++) begin : g_hart
        hctl_hart_slice #(.HAS_RESET(HAS_RESET)) u_slice (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_ctrl     (wr_ctrl),
            .wr_sel      (sel_new[i]),
            .wr_halt     (acc_wdata[C_HALT]),
            .wr_resume   (acc_wdata[C_RESUME]),
            .wr_hrst     (acc_wdata[C_HRST]),
            .wr_ack      (acc_wdata[C_ACK]),
            .halted      (hart_halted[i]),
            .running     (hart_running[i]),
            .reset_event (hart_reset_event[i]),
            .halt_req    (hart_halt_req[i]),
            .resume_req  (hart_resume_req[i]),
            .hrst        (hart_reset[i]),
            .seen        (seen_v[i]),
            .rack        (rack_v[i])
        );
    end

    hctl_summary #(.N_HARTS(N_HARTS)) u_sum_hlt  (.sel(sel_cur), .flags(hart_halted),  .sum(s_hlt));
    hctl_summary #(.N_HARTS(N_HARTS)) u_sum_run  (.sel(sel_cur), .flags(hart_running), .sum(s_run));
    hctl_summary #(.N_HARTS(N_HARTS)) u_sum_rst  (.sel(sel_cur), .flags(seen_v),       .sum(s_rst));
    hctl_summary #(.N_HARTS(N_HARTS)) u_sum_rack (.sel(sel_cur), .flags(rack_v),       .sum(s_rack));

    // stored selection fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            idx_q  <= '0;
            mask_q <= '0;
        end else if (wr_ctrl) begin
            mode_q <= acc_wdata[C_MODE];
            idx_q  <= acc_wdata[C_SEL_LO+:SEL_W];
            mask_q <= acc_wdata[N_HARTS-1:0];
        end
    end

    // sticky error code: first error kept until cleared
    always_ff @(posedge clk) begin
        if (!rst_n)                               err_q <= ERR_NONE;
        else if (err_clr)                         err_q <= ERR_NONE;
        else if (err_q == ERR_NONE) begin
            if (both)                             err_q <= ERR_OTHER;
            else if ((wr_ok || rd_ok) && bad_addr) err_q <= ERR_BADADDR;
        end
    end

    // reset level of the indexed hart for readback
    always_comb begin
        idx_rst = 1'b0;
        for (int i = 0; i < N_HARTS; i++) begin
            if (idx_q == SEL_W'(i)) idx_rst = hart_reset[i];
        end
    end

    // read data assembly for both registers
    always_comb begin
        ctrl_rd                    = '0;
        ctrl_rd[C_HRST]            = idx_rst;
        ctrl_rd[C_MODE]            = mode_q;
        ctrl_rd[C_SEL_LO+:SEL_W]   = idx_q;
        ctrl_rd[N_HARTS-1:0]       = mask_q;

        stat_rd                    = '0;
        stat_rd[S_ERR_LO+:3]       = err_q;
        stat_rd[S_ALL_RST]         = s_rst.all_set;
        stat_rd[S_ANY_RST]         = s_rst.any_set;
        stat_rd[S_ALL_RACK]        = s_rack.all_set;
        stat_rd[S_ANY_RACK]        = s_rack.any_set;
        stat_rd[S_ALL_RUN]         = s_run.all_set;
        stat_rd[S_ANY_RUN]         = s_run.any_set;
        stat_rd[S_ALL_HLT]         = s_hlt.all_set;
        stat_rd[S_ANY_HLT]         = s_hlt.any_set;
    end

    // registered read port
    always_ff @(posedge clk) begin
        if (!rst_n)              rdata_q <= '0;
        else if (rd_ok && is_ctrl) rdata_q <= ctrl_rd;
        else if (rd_ok && is_stat) rdata_q <= stat_rd;
        else                     rdata_q <= '0;
    end

    assign acc_rdata = rdata_q;

    assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_q != ERR_NONE) && !err_clr) |=> $stable(err_q));
    assert_badaddr_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_q == ERR_NONE) && wr_ok && bad_addr) |=> (err_q == ERR_BADADDR));
    assert_collision_inert_R12: assert property (@(posedge clk) disable iff (!rst_n)
        both |=> $stable(hart_halt_req));
    assert_all_any_R11: assert property (@(posedge clk) disable iff (!rst_n)
        s_hlt.all_set |-> s_hlt.any_set);
endmodule

// File: tb/hart_dbg_ctrl_bench.sv
module hart_dbg_ctrl_bench;
    localparam int N = 4;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic        acc_we = 1'b0, acc_re = 1'b0;
    logic [N-1:0] hart_halted = '0, hart_running = '0, hart_reset_event = '0;
    logic [31:0] acc_rdata;
    logic [N-1:0] hart_halt_req, hart_resume_req, hart_reset;
    int checks = 0, errors = 0;
    logic [31:0] rd;

    always #4 clk = ~clk;

    hart_dbg_ctrl #(.N_HARTS(N), .ADDR_W(7), .HAS_RESET(1'b1)) u_hart_dbg_ctrl (
        .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_we(acc_we), .acc_re(acc_re), .hart_halted(hart_halted),
        .hart_running(hart_running), .hart_reset_event(hart_reset_event),
        .acc_rdata(acc_rdata), .hart_halt_req(hart_halt_req),
        .hart_resume_req(hart_resume_req), .hart_reset(hart_reset));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk); acc_addr = a; acc_wdata = d; acc_we = 1'b1;
        @(negedge clk); acc_we = 1'b0;
    endtask

    task automatic rdreg(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk); acc_addr = a; acc_re = 1'b1;
        @(negedge clk); acc_re = 1'b0; d = acc_rdata;
    endtask

    function automatic logic [31:0] ctl(input bit halt, input bit res, input bit hr,
        input bit ack, input bit mode, input int idx, input logic [15:0] mask);
        return {halt, res, hr, ack, 1'b0, mode, 10'(idx), mask};
    endfunction

    function automatic logic [N-1:0] selv(input bit mode, input int idx, input logic [15:0] mask);
        logic [N-1:0] s = mode ? mask[N-1:0] : '0;
        if (idx < N) s[idx] = 1'b1;
        return s;
    endfunction

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state (R1)
        chk("R1 reset halt", 32'(hart_halt_req), 0);
        chk("R1 reset resume", 32'(hart_resume_req), 0);
        rdreg(7'h10, rd); chk("R1 ctrl after reset", rd, 0);
        rdreg(7'h11, rd); chk("R1 stat after reset", rd, 0);
        @(negedge clk); chk("R1 rdata idle zero", acc_rdata, 0);

        // selection sweep (R2, R3, R10, R13)
        for (int m = 0; m < 2; m++) begin
            for (int ix = 0; ix < 5; ix++) begin
                for (int mk = 0; mk < 16; mk++) begin
                    wr(7'h10, ctl(0, 0, 0, 0, 1, 0, 16'hF));
                    wr(7'h10, ctl(1, 0, 0, 0, m[0], ix, 16'(mk)));
                    chk("R2 R3 R10 halt sel", 32'(hart_halt_req), 32'(selv(m[0], ix, 16'(mk))));
                    rdreg(7'h10, rd);
                    chk("R13 ctrl readback", rd, {5'b0, m[0], 10'(ix), 16'(mk)});
                end
            end
        end
        wr(7'h10, ctl(0, 0, 0, 0, 1, 0, 16'hF));

        // halted/running summaries (R11)
        wr(7'h10, ctl(0, 0, 0, 0, 1, 1, 16'h4));
        for (int h = 0; h < 16; h++) begin
            logic [N-1:0] hv, sv, rv;
            logic [31:0] e;
            hv = 4'(h); sv = 4'b0110; rv = ~hv;
            hart_halted = hv; hart_running = rv;
            rdreg(7'h11, rd);
            e = '0;
            e[9]  = ((hv & sv) == sv); e[8]  = |(hv & sv);
            e[11] = ((rv & sv) == sv); e[10] = |(rv & sv);
            chk("R11 summary", rd & 32'h0F00, e);
        end
        wr(7'h10, ctl(0, 0, 0, 0, 0, 5, 16'h0));
        hart_halted = 4'hF; hart_running = 4'h0;
        rdreg(7'h11, rd); chk("R11 empty selection", rd, 0);

        // resume (R4, R5, R6)
        hart_halted = 4'b0011; hart_running = 4'b1100;
        wr(7'h10, ctl(1, 1, 0, 0, 1, 0, 16'hF));
        chk("R5 resume ignored with halt", 32'(hart_resume_req), 0);
        wr(7'h10, ctl(0, 1, 0, 0, 1, 0, 16'hF));
        chk("R4 resume to halted only", 32'(hart_resume_req), 32'b0011);
        repeat (3) @(negedge clk);
        chk("R4 resume held", 32'(hart_resume_req), 32'b0011);
        rdreg(7'h11, rd); chk("R6 ack flags cleared", rd & 32'h30000, 0);
        hart_halted = 4'b0000; hart_running = 4'b1111;
        @(negedge clk);
        chk("R4 resume dropped on running", 32'(hart_resume_req), 0);
        rdreg(7'h11, rd); chk("R6 any not all", rd & 32'h30000, 32'h10000);
        wr(7'h10, ctl(0, 0, 0, 0, 1, 0, 16'h2));
        rdreg(7'h11, rd); chk("R6 all acked", rd & 32'h30000, 32'h30000);

        // hart reset, reset-seen, acknowledge (R7, R8, R9)
        wr(7'h10, ctl(0, 0, 1, 0, 1, 0, 16'h3));
        chk("R7 reset level", 32'(hart_reset), 32'b0011);
        rdreg(7'h10, rd); chk("R7 reset readback", rd[29], 1);
        wr(7'h10, ctl(0, 0, 0, 0, 1, 0, 16'h3));
        chk("R7 reset released", 32'(hart_reset), 0);
        @(negedge clk); hart_reset_event = 4'b0101;
        @(negedge clk); hart_reset_event = 4'b0000;
        wr(7'h10, ctl(0, 0, 0, 0, 1, 0, 16'hF));
        rdreg(7'h11, rd); chk("R8 any not all", rd & 32'hC0000, 32'h40000);
        wr(7'h10, ctl(0, 0, 0, 0, 1, 0, 16'h5));
        rdreg(7'h11, rd); chk("R8 all seen", rd & 32'hC0000, 32'hC0000);
        wr(7'h10, ctl(0, 0, 0, 1, 0, 2, 16'h0));
        rdreg(7'h11, rd); chk("R9 ack clears hart2", rd & 32'hC0000, 0);
        wr(7'h10, ctl(0, 0, 0, 0, 0, 0, 16'h0));
        rdreg(7'h11, rd); chk("R9 hart0 untouched", rd & 32'hC0000, 32'hC0000);
        // collision: reset pulse in the ack cycle
        @(negedge clk); acc_addr = 7'h10; acc_wdata = ctl(0, 0, 0, 1, 0, 0, 16'h0);
        acc_we = 1'b1; hart_reset_event = 4'b0001;
        @(negedge clk); acc_we = 1'b0; hart_reset_event = 4'b0000;
        rdreg(7'h11, rd); chk("R9 pulse beats ack", rd & 32'h40000, 32'h40000);
        wr(7'h10, ctl(0, 0, 0, 1, 0, 0, 16'h0));
        rdreg(7'h11, rd); chk("R9 ack alone clears", rd & 32'h40000, 0);

        // errors (R1, R12)
        rdreg(7'h05, rd); chk("R1 bad addr reads zero", rd, 0);
        rdreg(7'h11, rd); chk("R12 badaddr code", 32'(rd[26:24]), 1);
        @(negedge clk); acc_addr = 7'h10; acc_wdata = ctl(1, 0, 0, 0, 1, 0, 16'hF);
        acc_we = 1'b1; acc_re = 1'b1;
        @(negedge clk); acc_we = 1'b0; acc_re = 1'b0;
        chk("R12 collision inert", 32'(hart_halt_req), 0);
        rdreg(7'h11, rd); chk("R12 first code kept", 32'(rd[26:24]), 1);
        wr(7'h11, 32'h0700_0000);
        rdreg(7'h11, rd); chk("R12 cleared", 32'(rd[26:24]), 0);
        @(negedge clk); acc_we = 1'b1; acc_re = 1'b1;
        @(negedge clk); acc_we = 1'b0; acc_re = 1'b0;
        chk("R12 collision inert 2", 32'(hart_halt_req), 0);
        rdreg(7'h11, rd); chk("R12 other code", 32'(rd[26:24]), 7);
        wr(7'h11, 32'h0700_0000);
        wr(7'h33, 32'hFFFF_FFFF);
        rdreg(7'h11, rd); chk("R12 bad write code", 32'(rd[26:24]), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule